// File: doc/BRIEF.md
# Privilege-Qualified Debug Hit Filter

This block sits after the address comparators of a processor's debug logic. Those comparators raise raw hit strobes: one for the instruction-address breakpoint and one for each of two data watchpoints. On its own, a raw hit does not mean the core should take a debug exception. The filter checks each strobe against the current machine state and passes on only the hits that qualify. The machine state it uses is the user-state bit, the hypervisor bit and the data-translation bit, together with two feature-level enables.

The breakpoint is governed by a 2-bit privilege selector. Each watchpoint has a 5-bit control field. That field holds privilege enables and a translation-match rule, which can compare the data-translation bit or ignore it.

Each qualified hit produces a registered event one cycle later, with a status word already formed. A qualified watchpoint produces a data-storage event that carries the faulting address. A qualified breakpoint produces a trace event.

Top module: `dbg_qual_top`

## Requirements
- R1: With breakpoint selector `bpPriv` = 1, a raw breakpoint hit qualifies only when `stPr` = 1.
- R2: With `bpPriv` = 2, a breakpoint hit qualifies only when `stPr` = 0 and `stHv` = 0. With `bpPriv` = 3, it qualifies only when `stPr` = 0 and `stHv` = 1.
- R3: With `bpPriv` = 0, no breakpoint hit ever qualifies. This is a legal disabled setting.
- R4: Each watchpoint control field has the layout bit0 = user enable, bit1 = supervisor enable, bit2 = hypervisor enable, bit3 = ignore-translation, bit4 = translation-match value. A watchpoint hit is rejected in three cases: `stPr` = 1 with bit0 clear, `stHv` = 1 with bit2 clear, or bit1 clear.
- R5: A watchpoint hit that survives R4 with bit3 clear qualifies only when `stDr` equals bit4. With bit3 set, `stDr` is ignored.
- R6: The breakpoint and watchpoint 0 can qualify only while `featBase` = 1. Watchpoint 1 can qualify only while `featNew` = 1.
- R7: Every output is registered. A qualified hit appears exactly one clock after its raw strobe, and all outputs read zero during reset.
- R8: When any watchpoint qualifies, `evtDsi` = 1 and `evtAddr` holds `wpAddr`. In `evtStatus`, only the bit at big-endian position 41 is set, which is LSB index STATUS_W-1-41. This event takes precedence over the trace event.
- R9: When the breakpoint qualifies and no watchpoint does, `evtTrace` = 1 and `evtAddr` = 0. In `evtStatus`, only big-endian bits 33 and 43 are set. With no qualified hit, the status word is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stPr | input | 1 | Machine state: user mode |
| stHv | input | 1 | Machine state: hypervisor mode |
| stDr | input | 1 | Machine state: data translation on |
| featBase | input | 1 | Base debug feature level enabled |
| featNew | input | 1 | Newer debug feature level enabled |
| bpPriv | input | 2 | Breakpoint privilege selector |
| bpRawHit | input | 1 | Raw breakpoint address match |
| wpCtrl | input | 2x5 | Per-watchpoint control fields |
| wpRawHit | input | 2 | Raw watchpoint address matches |
| wpAddr | input | ADDR_W | Data address of the current access |
| bpHit | output | 1 | Qualified breakpoint hit |
| wpHit | output | 2 | Qualified watchpoint hits |
| evtDsi | output | 1 | Data-storage event raised |
| evtTrace | output | 1 | Trace event raised |
| evtAddr | output | ADDR_W | Address reported with a data-storage event |
| evtStatus | output | STATUS_W | Status code for the raised event |

## Verification
The assertions assume three things about the inputs: they are stable around the rising edge, `wpAddr` belongs to the same access as the raw watchpoint strobes, and every input holds a known value in each sampled cycle, so `$past` comparisons of selector and state are meaningful.

The bench drives every input on the falling edge from a fixed seed. It covers all four selector values, every privilege state combination, both feature levels, and raw hits that collide on the same cycle. In every cycle each output is compared with a behavioural model that is one cycle behind.

// File: rtl/dbg_qual_pkg.sv
package dbg_qual_pkg;
  localparam int WP_COUNT = 2;
  localparam int WPC_W    = 5;
  // watchpoint control field bit positions
  localparam int WPC_PR   = 0;
  localparam int WPC_SV   = 1;
  localparam int WPC_HV   = 2;
  localparam int WPC_WTI  = 3;
  localparam int WPC_WT   = 4;
  // status bits in big-endian numbering
  localparam int DSI_BIT_BE    = 41;
  localparam int TRACE_BIT_A_BE = 33;
  localparam int TRACE_BIT_B_BE = 43;

  typedef struct packed {
    logic                bp;
    logic [WP_COUNT-1:0] wp;
  } qualStrobe_t;
endpackage

// File: rtl/dbg_qual_ctrl.sv
module dbg_qual_ctrl
  import dbg_qual_pkg::*;
(
  input  logic                            stPr,
  input  logic                            stHv,
  input  logic                            stDr,
  input  logic                            featBase,
  input  logic                            featNew,
  input  logic [1:0]                      bpPriv,
  input  logic                            bpRawHit,
  input  logic [WP_COUNT-1:0][WPC_W-1:0]  wpCtrl,
  input  logic [WP_COUNT-1:0]             wpRawHit,
  output qualStrobe_t                     strobe
);
  logic bpPrivOk;
  logic [WP_COUNT-1:0] wpQual;

  always_comb begin
    unique case (bpPriv)
      2'd1:    bpPrivOk = stPr;
      2'd2:    bpPrivOk = !stPr && !stHv;
      2'd3:    bpPrivOk = !stPr && stHv;
      default: bpPrivOk = 1'b0;
    endcase
  end

  for (genvar i = 0; i < WP_COUNT; i++) begin : g_wp
    logic featOk, privOk, xlatOk;
    if (i == 0) begin : g_base
      assign featOk = featBase;
    end else begin : g_new
      assign featOk = featNew;
    end
    assign privOk = !(stPr && !wpCtrl[i][WPC_PR])
                 && !(stHv && !wpCtrl[i][WPC_HV])
                 && wpCtrl[i][WPC_SV];
    assign xlatOk = wpCtrl[i][WPC_WTI] || (stDr == wpCtrl[i][WPC_WT]);
    assign wpQual[i] = wpRawHit[i] && featOk && privOk && xlatOk;
  end

  always_comb begin
    strobe.bp = bpRawHit && featBase && bpPrivOk;
    strobe.wp = wpQual;
  end
endmodule

// File: rtl/dbg_qual_dp.sv
module dbg_qual_dp
  import dbg_qual_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int STATUS_W = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  qualStrobe_t         strobe,
  input  logic [ADDR_W-1:0]   wpAddr,
  output logic                bpHit,
  output logic [WP_COUNT-1:0] wpHit,
  output logic                evtDsi,
  output logic                evtTrace,
  output logic [ADDR_W-1:0]   evtAddr,
  output logic [STATUS_W-1:0] evtStatus
);
  localparam int DSI_IDX = STATUS_W - 1 - DSI_BIT_BE;
  localparam int TRA_IDX = STATUS_W - 1 - TRACE_BIT_A_BE;
  localparam int TRB_IDX = STATUS_W - 1 - TRACE_BIT_B_BE;

  logic anyWp, traceNext;
  logic [STATUS_W-1:0] statusNext;

  always_comb begin
    anyWp      = |strobe.wp;
    traceNext  = strobe.bp && !anyWp;
    statusNext = '0;
    if (anyWp) begin
      statusNext[DSI_IDX] = 1'b1;
    end else if (traceNext) begin
      statusNext[TRA_IDX] = 1'b1;
      statusNext[TRB_IDX] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bpHit     <= 1'b0;
      wpHit     <= '0;
      evtDsi    <= 1'b0;
      evtTrace  <= 1'b0;
      evtAddr   <= '0;
      evtStatus <= '0;
    end else begin
      bpHit     <= strobe.bp;
      wpHit     <= strobe.wp;
      evtDsi    <= anyWp;
      evtTrace  <= traceNext;
      evtAddr   <= anyWp ? wpAddr : '0;
      evtStatus <= statusNext;
    end
  end
endmodule

// File: rtl/dbg_qual_top.sv
module dbg_qual_top
  import dbg_qual_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int STATUS_W = 64
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           stPr,
  input  logic                           stHv,
  input  logic                           stDr,
  input  logic                           featBase,
  input  logic                           featNew,
  input  logic [1:0]                     bpPriv,
  input  logic                           bpRawHit,
  input  logic [WP_COUNT-1:0][WPC_W-1:0] wpCtrl,
  input  logic [WP_COUNT-1:0]            wpRawHit,
  input  logic [ADDR_W-1:0]              wpAddr,
  output logic                           bpHit,
  output logic [WP_COUNT-1:0]            wpHit,
  output logic                           evtDsi,
  output logic                           evtTrace,
  output logic [ADDR_W-1:0]              evtAddr,
  output logic [STATUS_W-1:0]            evtStatus
);
  qualStrobe_t strobe;

  dbg_qual_ctrl ctrl_i (
    .stPr(stPr), .stHv(stHv), .stDr(stDr),
    .featBase(featBase), .featNew(featNew),
    .bpPriv(bpPriv), .bpRawHit(bpRawHit),
    .wpCtrl(wpCtrl), .wpRawHit(wpRawHit),
    .strobe(strobe)
  );

  dbg_qual_dp #(.ADDR_W(ADDR_W), .STATUS_W(STATUS_W)) dp_i (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .wpAddr(wpAddr),
    .bpHit(bpHit), .wpHit(wpHit), .evtDsi(evtDsi), .evtTrace(evtTrace),
    .evtAddr(evtAddr), .evtStatus(evtStatus)
  );
endmodule

// File: rtl/dbg_qual_chk.sv
module dbg_qual_chk
  import dbg_qual_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int STATUS_W = 64
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           stPr,
  input logic                           stHv,
  input logic                           featBase,
  input logic                           featNew,
  input logic [1:0]                     bpPriv,
  input logic                           bpRawHit,
  input logic [WP_COUNT-1:0][WPC_W-1:0] wpCtrl,
  input logic [WP_COUNT-1:0]            wpRawHit,
  input logic [ADDR_W-1:0]              wpAddr,
  input logic                           bpHit,
  input logic [WP_COUNT-1:0]            wpHit,
  input logic                           evtDsi,
  input logic                           evtTrace,
  input logic [ADDR_W-1:0]              evtAddr,
  input logic [STATUS_W-1:0]            evtStatus
);
  localparam logic [STATUS_W-1:0] TRACE_CODE =
    (STATUS_W'(1) << (STATUS_W - 1 - TRACE_BIT_A_BE)) |
    (STATUS_W'(1) << (STATUS_W - 1 - TRACE_BIT_B_BE));

  assert_bp_user_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bpHit && $past(bpPriv) == 2'd1) |-> $past(stPr));
  assert_bp_hyp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bpHit && $past(bpPriv) == 2'd3) |-> (!$past(stPr) && $past(stHv)));
  assert_bp_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bpHit |-> $past(bpPriv) != 2'd0);
  assert_wp_user_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wpHit[0] && $past(stPr)) |-> $past(wpCtrl[0][WPC_PR]));
  assert_wp1_feat_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wpHit[1] |-> $past(featNew));
  assert_bp_feat_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bpHit |-> $past(featBase));
  assert_bp_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bpHit |-> $past(bpRawHit));
  assert_wp_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wpHit[0] |-> $past(wpRawHit[0]));
  assert_dsi_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    evtDsi |-> evtAddr == $past(wpAddr));
  assert_one_event_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({evtDsi, evtTrace}));
  assert_trace_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
    evtTrace |-> evtStatus == TRACE_CODE);
endmodule

bind dbg_qual_top dbg_qual_chk #(.ADDR_W(ADDR_W), .STATUS_W(STATUS_W)) chk_i (.*);

// File: tb/dbg_qual_top_tb_top.sv
module dbg_qual_top_tb_top;
  localparam int AW = 32;
  localparam int SW = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stPr = 0, stHv = 0, stDr = 0, featBase = 0, featNew = 0;
  logic [1:0] bpPriv = 0;
  logic bpRawHit = 0;
  logic [1:0][4:0] wpCtrl = '0;
  logic [1:0] wpRawHit = 0;
  logic [AW-1:0] wpAddr = '0;
  logic bpHit, evtDsi, evtTrace;
  logic [1:0] wpHit;
  logic [AW-1:0] evtAddr;
  logic [SW-1:0] evtStatus;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic expBp = 0, expDsi = 0, expTrace = 0;
  logic [1:0] expWp = 0;
  logic [AW-1:0] expAddr = '0;
  logic [SW-1:0] expStatus = '0;
  string expTag = "R7";

  always #4 clk = ~clk;

  dbg_qual_top #(.ADDR_W(AW), .STATUS_W(SW)) dut_i (.*);

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic bit wpModel(bit pr, bit hv, bit dr, bit feat, bit raw, logic [4:0] c);
    if (!raw || !feat) return 0;
    if (pr && !c[0]) return 0;
    else if (hv && !c[2]) return 0;
    else if (!c[1]) return 0;
    if (!c[3] && (dr != c[4])) return 0;
    return 1;
  endfunction

  task automatic compareAll();
    chk(expTag, "bpHit", 64'(bpHit), 64'(expBp));
    chk(expTag, "wpHit", 64'(wpHit), 64'(expWp));
    chk(expTag, "evtDsi", 64'(evtDsi), 64'(expDsi));
    chk(expTag, "evtTrace", 64'(evtTrace), 64'(expTrace));
    chk(expTag, "evtAddr", 64'(evtAddr), 64'(expAddr));
    chk(expTag, "evtStatus", evtStatus, expStatus);
  endtask

  task automatic step(string tag, bit pr, bit hv, bit dr, bit fb, bit fn,
                      logic [1:0] bpp, bit bpr, logic [4:0] c0, logic [4:0] c1,
                      logic [1:0] wr, logic [AW-1:0] addr);
    bit b;
    bit [1:0] w;
    @(negedge clk);
    compareAll();
    stPr = pr; stHv = hv; stDr = dr; featBase = fb; featNew = fn;
    bpPriv = bpp; bpRawHit = bpr; wpCtrl[0] = c0; wpCtrl[1] = c1;
    wpRawHit = wr; wpAddr = addr;
    case (bpp)
      2'd1: b = pr;
      2'd2: b = !pr && !hv;
      2'd3: b = !pr && hv;
      default: b = 0;
    endcase
    b = b && bpr && fb;
    w[0] = wpModel(pr, hv, dr, fb, wr[0], c0);
    w[1] = wpModel(pr, hv, dr, fn, wr[1], c1);
    expBp = b; expWp = w; expTag = tag;
    expDsi = |w;
    expTrace = b && !(|w);
    expAddr = (|w) ? addr : '0;
    expStatus = '0;
    if (|w) expStatus[SW-1-41] = 1'b1;
    else if (b) begin
      expStatus[SW-1-33] = 1'b1;
      expStatus[SW-1-43] = 1'b1;
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual hung expected done");
    finishRun();
  end

  initial begin
    int unsigned seed = 32'h1234;
    // reset state, R7
    repeat (3) @(negedge clk);
    stPr = 1; bpPriv = 1; bpRawHit = 1; featBase = 1;
    @(negedge clk);
    chk("R7 reset", "bpHit", 64'(bpHit), 64'd0);
    chk("R7 reset", "evtStatus", evtStatus, 64'd0);
    bpRawHit = 0;
    rst_n = 1;
    // R1: user selector
    step("R1", 1,0,0, 1,1, 2'd1, 1, 5'h00, 5'h00, 2'b00, 32'h0);
    step("R1", 0,0,0, 1,1, 2'd1, 1, 5'h00, 5'h00, 2'b00, 32'h0);
    // R2: supervisor and hypervisor selectors
    step("R2", 0,0,0, 1,1, 2'd2, 1, 5'h00, 5'h00, 2'b00, 32'h0);
    step("R2", 0,1,0, 1,1, 2'd2, 1, 5'h00, 5'h00, 2'b00, 32'h0);
    step("R2", 0,1,0, 1,1, 2'd3, 1, 5'h00, 5'h00, 2'b00, 32'h0);
    step("R2", 1,1,0, 1,1, 2'd3, 1, 5'h00, 5'h00, 2'b00, 32'h0);
    // R3: disabled selector in every state
    step("R3", 1,0,0, 1,1, 2'd0, 1, 5'h00, 5'h00, 2'b00, 32'h0);
    step("R3", 0,1,0, 1,1, 2'd0, 1, 5'h00, 5'h00, 2'b00, 32'h0);
    step("R3", 0,0,0, 1,1, 2'd0, 1, 5'h00, 5'h00, 2'b00, 32'h0);
    // R4: privilege enables (0x0F = pr,sv,hv,wti)
    step("R4", 1,0,0, 1,1, 2'd0, 0, 5'h0E, 5'h0F, 2'b11, 32'hA000_0010);
    step("R4", 0,1,0, 1,1, 2'd0, 0, 5'h0B, 5'h0F, 2'b11, 32'hA000_0020);
    step("R4", 0,0,0, 1,1, 2'd0, 0, 5'h0D, 5'h0A, 2'b11, 32'hA000_0030);
    // R5: translation match
    step("R5", 0,0,1, 1,1, 2'd0, 0, 5'h12, 5'h02, 2'b11, 32'hB000_0040);
    step("R5", 0,0,0, 1,1, 2'd0, 0, 5'h12, 5'h02, 2'b11, 32'hB000_0050);
    step("R5", 0,0,1, 1,1, 2'd0, 0, 5'h0A, 5'h1A, 2'b11, 32'hB000_0060);
    // R6: feature levels
    step("R6", 0,0,0, 0,1, 2'd2, 1, 5'h0F, 5'h0F, 2'b11, 32'hC000_0070);
    step("R6", 0,0,0, 1,0, 2'd2, 0, 5'h0F, 5'h0F, 2'b10, 32'hC000_0080);
    step("R6", 0,0,0, 1,0, 2'd2, 0, 5'h0F, 5'h0F, 2'b01, 32'hC000_0090);
    // R8: watchpoint beats breakpoint
    step("R8", 0,0,0, 1,1, 2'd2, 1, 5'h0F, 5'h00, 2'b01, 32'hD000_00A0);
    // R9: lone breakpoint, then idle
    step("R9", 0,0,0, 1,1, 2'd2, 1, 5'h0F, 5'h0F, 2'b00, 32'hD000_00B0);
    step("R9", 0,0,0, 1,1, 2'd2, 0, 5'h0F, 5'h0F, 2'b00, 32'hD000_00C0);
    // random mix
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] r;
      r = $urandom(seed + n);
      step("R7 random", r[0], r[1], r[2], r[3] | r[20], r[4] | r[21], r[6:5], r[7],
           r[12:8], r[17:13], r[19:18], $urandom());
    end
    step("R7", 0,0,0, 0,0, 2'd0, 0, 5'h00, 5'h00, 2'b00, 32'h0);
    finishRun();
  end
endmodule